// File: doc/BRIEF.md
# Persistence-Filtered Fault Channel

This block watches one sampled measurement and decides, with time filtering on both edges, whether a protection fault is present. A measurement sample is presented together with a one-cycle strobe, typically once per control period (10 us in a power stage). An excursion past the trip threshold must persist for a programmable number of samples before the fault is raised. Once raised, the fault holds until the measurement has been back inside a separate, usually tighter, clear threshold for its own programmable number of samples.

While the fault is set, a drive-disable output tells the modulator to force every switching output off. A polarity input selects an over-limit channel (value too high) or an under-limit channel (value too low). Combining several channels and deciding when to restart are left to the surrounding logic.

Top module: `fault_chan_mon`

## Requirements
- R1: While rst_ni is low, fault_o and pwm_off_o are 0 and both persistence counters are cleared. The first strobe after reset starts counting from zero.
- R2: With min_mode_i=0 and fault_o=0, a strobed sample with value_i > trip_thr_i (unsigned) is qualifying. fault_o rises on the clock edge that takes the (blank_cnt_i+1)-th consecutive qualifying sample, so it is visible in the following cycle.
- R3: A strobed sample that is not qualifying, taken while the fault is clear, resets the blanking count to zero.
- R4: pwm_off_o equals fault_o in every cycle.
- R5: With min_mode_i=0 and fault_o=1, a strobed sample with value_i < clr_thr_i is clearing. fault_o falls on the edge that takes the (clr_cnt_i+1)-th consecutive clearing sample.
- R6: A strobed non-clearing sample taken while the fault is set restarts the clear count from zero.
- R7: With min_mode_i=1 both comparisons are mirrored. Qualifying means value_i < trip_thr_i, and clearing means value_i > clr_thr_i.
- R8: A count setting of 0 acts on the first qualifying (or clearing) sample.
- R9: Cycles with sample_i=0 change neither fault_o nor either count, whatever value_i holds.
- R10: Comparisons are strict. A value equal to a threshold neither qualifies nor clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | One-cycle strobe marking a valid sample |
| value_i | input | DATA_W | Measured value, unsigned |
| trip_thr_i | input | DATA_W | Trip threshold |
| clr_thr_i | input | DATA_W | Clear threshold |
| blank_cnt_i | input | CNT_W | Extra qualifying samples needed before tripping |
| clr_cnt_i | input | CNT_W | Extra clearing samples needed before release |
| min_mode_i | input | 1 | 0: over-limit channel, 1: under-limit channel |
| fault_o | output | 1 | Fault active |
| pwm_off_o | output | 1 | Force all drive outputs off |

## Verification
On every cycle the assertions check the following: the fault flag moves only on strobe edges, a rise follows a sample beyond the trip threshold, a fall follows a sample inside the clear threshold, zero-count settings act immediately, and the disable output tracks the flag. Only the bench scenarios can show the exact number of samples needed to trip or release, the restart of a count after an interrupted run, and the mirrored behaviour in under-limit mode. These depend on sequences longer than any single property.

// File: rtl/fault_mon_pkg.sv
package fault_mon_pkg;
  typedef enum logic {
    SENSE_ABOVE = 1'b0,
    SENSE_BELOW = 1'b1
  } sense_e;
endpackage

// File: rtl/fm_thr_cmp.sv
module fm_thr_cmp
  import fault_mon_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] value_i,
  input  logic [DATA_W-1:0] thr_i,
  input  sense_e            sense_i,
  output logic              beyond_o
);
  always_comb begin
    if (sense_i == SENSE_BELOW) beyond_o = value_i < thr_i;
    else                        beyond_o = value_i > thr_i;
  end
endmodule

// File: rtl/fm_persist_tmr.sv
module fm_persist_tmr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             en_i,
  input  logic             qual_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             fire_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign fire_o = en_i && qual_i && (cnt_q >= limit_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (flush_i || fire_o || (en_i && !qual_i)) begin
      cnt_q <= '0;
    end else if (en_i && qual_i && cnt_q != CntMax) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fault_chan_mon.sv
module fault_chan_mon
  import fault_mon_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [DATA_W-1:0] value_i,
  input  logic [DATA_W-1:0] trip_thr_i,
  input  logic [DATA_W-1:0] clr_thr_i,
  input  logic [CNT_W-1:0]  blank_cnt_i,
  input  logic [CNT_W-1:0]  clr_cnt_i,
  input  logic              min_mode_i,
  output logic              fault_o,
  output logic              pwm_off_o
);
  logic   fault_q;
  logic   trip_hit, clr_hit;
  logic   blank_fire, clr_fire;
  logic [CNT_W-1:0] blank_q, clrc_q;
  sense_e trip_sense, clr_sense;

  assign trip_sense = min_mode_i ? SENSE_BELOW : SENSE_ABOVE;
  // clear side looks the opposite way
  assign clr_sense  = min_mode_i ? SENSE_ABOVE : SENSE_BELOW;

  fm_thr_cmp #(.DATA_W(DATA_W)) u_trip_cmp (
    .value_i(value_i), .thr_i(trip_thr_i), .sense_i(trip_sense), .beyond_o(trip_hit)
  );

  fm_thr_cmp #(.DATA_W(DATA_W)) u_clr_cmp (
    .value_i(value_i), .thr_i(clr_thr_i), .sense_i(clr_sense), .beyond_o(clr_hit)
  );

  fm_persist_tmr #(.CNT_W(CNT_W)) u_blank_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(fault_q),
    .en_i(sample_i && !fault_q), .qual_i(trip_hit), .limit_i(blank_cnt_i),
    .fire_o(blank_fire), .cnt_o(blank_q)
  );

  fm_persist_tmr #(.CNT_W(CNT_W)) u_clr_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(!fault_q),
    .en_i(sample_i && fault_q), .qual_i(clr_hit), .limit_i(clr_cnt_i),
    .fire_o(clr_fire), .cnt_o(clrc_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         fault_q <= 1'b0;
    else if (blank_fire) fault_q <= 1'b1;
    else if (clr_fire)   fault_q <= 1'b0;
  end

  assign fault_o   = fault_q;
  assign pwm_off_o = fault_q;
endmodule

// File: rtl/fault_chan_mon_chk.sv
module fault_chan_mon_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_i,
  input logic [DATA_W-1:0] value_i,
  input logic [DATA_W-1:0] trip_thr_i,
  input logic [DATA_W-1:0] clr_thr_i,
  input logic [CNT_W-1:0]  blank_cnt_i,
  input logic [CNT_W-1:0]  clr_cnt_i,
  input logic              min_mode_i,
  input logic              fault_o,
  input logic              pwm_off_o
);
  logic trip_c, clr_c;
  assign trip_c = min_mode_i ? (value_i < trip_thr_i) : (value_i > trip_thr_i);
  assign clr_c  = min_mode_i ? (value_i > clr_thr_i)  : (value_i < clr_thr_i);

  assert_pwm_tracks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_off_o == fault_o);

  assert_hold_no_strobe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(fault_o));

  assert_rise_on_trip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !fault_o && !trip_c) |=> !fault_o);

  assert_fall_on_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && fault_o && !clr_c) |=> fault_o);

  assert_zero_blank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !fault_o && trip_c && blank_cnt_i == '0) |=> fault_o);

  assert_zero_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && fault_o && clr_c && clr_cnt_i == '0) |=> !fault_o);
endmodule

bind fault_chan_mon fault_chan_mon_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_fault_chan_mon.sv
module tb_fault_chan_mon;
  localparam int DW = 16;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sample = 1'b0, min_mode = 1'b0;
  logic [DW-1:0] value = '0, trip_thr = '0, clr_thr = '0;
  logic [CW-1:0] blank_cnt = '0, clr_cnt = '0;
  logic fault, pwm_off;

  int n_chk = 0, n_bad = 0;
  bit m_fault = 1'b0;
  int m_bc = 0, m_cc = 0;

  always #2 clk = ~clk;

  fault_chan_mon #(.DATA_W(DW), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .value_i(value),
    .trip_thr_i(trip_thr), .clr_thr_i(clr_thr), .blank_cnt_i(blank_cnt),
    .clr_cnt_i(clr_cnt), .min_mode_i(min_mode), .fault_o(fault), .pwm_off_o(pwm_off)
  );

  function automatic bit f_trip(bit mm, int v, int t);
    return mm ? (v < t) : (v > t);
  endfunction

  function automatic bit f_clear(bit mm, int v, int t);
    return mm ? (v > t) : (v < t);
  endfunction

  task automatic model_edge();
    if (!sample) return;
    if (!m_fault) begin
      if (f_trip(min_mode, int'(value), int'(trip_thr))) begin
        if (m_bc >= int'(blank_cnt)) begin m_fault = 1'b1; m_bc = 0; m_cc = 0; end
        else m_bc++;
      end else m_bc = 0;
    end else begin
      if (f_clear(min_mode, int'(value), int'(clr_thr))) begin
        if (m_cc >= int'(clr_cnt)) begin m_fault = 1'b0; m_cc = 0; m_bc = 0; end
        else m_cc++;
      end else m_cc = 0;
    end
  endtask

  task automatic check(string tag);
    n_chk++;
    if (fault !== m_fault || pwm_off !== m_fault) begin
      n_bad++;
      $display("FAIL %s: fault=%b pwm_off=%b expected %b", tag, fault, pwm_off, m_fault);
    end
  endtask

  // drive at negedge, clock once, compare at next negedge
  task automatic step(bit s, int v, string tag);
    sample = s;
    value  = DW'(v);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic setup(bit mm, int tt, int ct, int bl, int cl);
    min_mode = mm; trip_thr = DW'(tt); clr_thr = DW'(ct);
    blank_cnt = CW'(bl); clr_cnt = CW'(cl);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    setup(0, 1000, 900, 3, 2);
    value = 16'hFFFF; sample = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset state");
    sample = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // R2: blank=3 needs four consecutive qualifying samples
    for (int i = 0; i < 3; i++) step(1, 1500, "R2 counting");
    step(0, 2000, "R9 idle cycle");
    step(1, 1500, "R2 trips on 4th");
    // R5: clear=2 needs three samples below 900
    step(1, 899, "R5 clear 1");
    step(1, 950, "R6 restart");
    step(1, 899, "R5 clear 1 again");
    step(1, 899, "R5 clear 2");
    step(0, 0, "R9 idle no clear");
    step(1, 900, "R10 equal not clearing");
    for (int i = 0; i < 3; i++) step(1, 10, "R5 release");
    // R3 interruption
    step(1, 1001, "R3 a");
    step(1, 1001, "R3 b");
    step(1, 1000, "R10 equal not trip");
    step(1, 1001, "R3 c");
    step(1, 1001, "R3 d");
    step(1, 1001, "R3 e");
    step(1, 1001, "R2 trip after reset count");
    // R8 zero counts
    setup(0, 1000, 900, 0, 0);
    step(1, 10, "R8 immediate clear");
    step(1, 1001, "R8 immediate trip");
    step(1, 10, "R8 immediate clear 2");
    // R7 min polarity
    setup(1, 500, 600, 1, 1);
    step(1, 499, "R7 min count");
    step(1, 1000, "R7 min reset");
    step(1, 499, "R7 min count 1");
    step(1, 499, "R7 min trip");
    step(1, 550, "R7 min not clearing");
    step(1, 601, "R7 min clear 1");
    step(1, 601, "R7 min release");

    // constrained random
    for (int blk = 0; blk < 40; blk++) begin
      int tt, ct;
      bit mm;
      mm = 1'($urandom_range(0, 1));
      tt = $urandom_range(200, 60000);
      ct = mm ? tt + $urandom_range(0, 100) : tt - $urandom_range(0, 100);
      setup(mm, tt, ct, $urandom_range(0, 5), $urandom_range(0, 5));
      for (int k = 0; k < 200; k++) begin
        int v;
        v = tt + $urandom_range(0, 300) - 150;
        if ($urandom_range(0, 7) == 0) v = ct;
        step(1'($urandom_range(0, 3) != 0), v, mm ? "R7 random" : "R2/R5 random");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : seed
    int unused;
    unused = $urandom(20240611);
  end
endmodule